// File: doc/BRIEF.md
# Primary Clock Loss Detector with Watchdog-Oscillator Fallback

This block watches the selected primary system clock from the slow, always-on watchdog oscillator. The watchdog clock domain keeps sending a request toggle across to the primary domain, and the primary domain echoes it back. The block counts watchdog cycles while it waits for each echo. If the echo does not return within a window that matches the minimum allowed primary period (about 1 ms, with the tolerance that the handshake latency adds), the block sets a sticky failure flag. It also emits a one-cycle non-maskable interrupt pulse, so a recovery routine can run.

After a primary failure the block moves the effective clock select to the watchdog oscillator. The CPU then keeps running on the slow clock. This fallback is withheld in two cases: when the watchdog oscillator is already the chosen source, and when the oscillator enable says it is unavailable. A second, mirror-image monitor runs in the primary domain and watches the watchdog oscillator. The output clock mux is a behavioural model only.

Software should drop both detection enables while it changes the source select, and may raise them again once the new select has been written. As a safety net, the block also restarts the primary window whenever the select changes.

Top module: `clk_fail_guard`

## Requirements
- R1: While reset is asserted and right after it, prim_fail, prim_fail_irq, wdo_fail, wdo_fail_irq and fallback are 0, and eff_sel is 2'b00.
- R2: With prim_det_en high and no primary clock activity, prim_fail rises on the (L+1)-th watchdog edge at which prim_det_en is sampled high, and not before. L = ceil(WDO_HZ / PRIM_MIN_HZ).
- R3: A primary clock that runs well above the floor never sets prim_fail.
- R4: prim_fail_irq is high for exactly one watchdog cycle, on the same edge at which prim_fail rises, once per rise.
- R5: prim_fail stays set until prim_fail_clr is sampled high. The clear takes effect on that edge, beats a new trip on that edge, and restarts the measurement window.
- R6: While prim_det_en is low, prim_fail never rises and the window is held at zero. On re-enable a full window of L+1 edges applies.
- R7: Any change of src_sel restarts the primary measurement window. A failure then needs a further L+1 edges after the edge at which the change is sampled.
- R8: One edge after prim_fail rises, fallback goes to 1 and eff_sel to 2'b11, provided the fallback is allowed. Both hold while prim_fail is set. One edge after prim_fail clears, eff_sel returns to src_sel and fallback to 0.
- R9: No fallback takes place when src_sel is 2'b11 (the watchdog oscillator) or when wdo_osc_en is 0. prim_fail and prim_fail_irq still behave as in R2 and R4.
- R10: Outside a fallback, eff_sel equals src_sel one watchdog edge later. Encoding: 00 internal oscillator, 01 crystal, 10 external clock input, 11 watchdog oscillator.
- R11: In the primary domain, with wdo_det_en high, a stopped watchdog clock sets wdo_fail after about W primary cycles, with one wdo_fail_irq pulse. W = ceil(SYS_MAX_HZ / WDO_MIN_HZ). wdo_fail_clr clears it. With wdo_det_en low it never sets.
- R12: sys_clk follows wdo_clk when eff_sel is 2'b11, and prim_clk otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wdo_clk | input | 1 | Watchdog oscillator clock, time base of the primary monitor |
| prim_clk | input | 1 | Currently selected primary clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prim_det_en | input | 1 | Primary failure detection enable (watchdog domain) |
| prim_fail_clr | input | 1 | Clears prim_fail (watchdog domain) |
| wdo_osc_en | input | 1 | Watchdog oscillator available for recovery |
| src_sel | input | 2 | Software clock source select |
| wdo_det_en | input | 1 | Watchdog oscillator failure detection enable (primary domain) |
| wdo_fail_clr | input | 1 | Clears wdo_fail (primary domain) |
| prim_fail | output | 1 | Sticky primary failure flag |
| prim_fail_irq | output | 1 | One-cycle non-maskable event on primary failure |
| wdo_fail | output | 1 | Sticky watchdog oscillator failure flag (primary domain) |
| wdo_fail_irq | output | 1 | One-cycle event on watchdog failure (primary domain) |
| eff_sel | output | 2 | Effective clock select after fallback |
| fallback | output | 1 | Automatic switchover to the watchdog oscillator in force |
| sys_clk | output | 1 | Behavioural system clock mux output |

## Verification
A corrupted window counter or a lost handshake phase shows up as prim_fail rising one or more edges early or late relative to L+1. The bench pins that edge exactly for a fresh enable and for a window restarted by a select change. A fallback register stuck wrong shows in eff_sel and fallback within one edge of the flag changing, or in an eff_sel that fails to follow src_sel. A stuck handshake in the mirror monitor appears as a wdo_fail that rises with the watchdog clock still running, or never rises once it stops.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [1:0] {
    SRC_INTOSC = 2'b00,
    SRC_XTAL   = 2'b01,
    SRC_EXTIN  = 2'b10,
    SRC_WDOSC  = 2'b11
  } clk_src_e;

  // Reference cycles that make up one minimum-rate period, rounded up.
  function automatic int unsigned window_cycles(input int unsigned ref_hz,
                                                input int unsigned min_hz);
    return (ref_hz + min_hz - 1) / min_hz;
  endfunction

  // Counter width able to hold the value 'limit'.
  function automatic int unsigned count_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cfd_sync.sv
module cfd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
      assign q = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfd_monitor.sv
module cfd_monitor
  import cfd_pkg::*;
#(
  parameter int unsigned LIMIT       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic meas_clk,
  input  logic rst_n,
  input  logic det_en,
  input  logic restart,
  input  logic fail_clr,
  output logic fail,
  output logic fail_irq
);
  localparam int unsigned CW      = count_width(LIMIT);
  localparam logic [CW-1:0] WIN_MAX = CW'(LIMIT);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic          req_q;
  logic          req_seen;
  logic          ack_s;
  logic [CW-1:0] cnt_q;
  logic          edge_seen;
  logic          window_full;
  logic          trip;
  logic          fail_q;
  logic          irq_q;

  // Echo path: the request crosses into the measured domain and back.
  cfd_sync #(.STAGES(SYNC_STAGES)) u_echo (
    .clk   (meas_clk),
    .rst_n (rst_n),
    .d     (req_q),
    .q     (req_seen)
  );

  cfd_sync #(.STAGES(SYNC_STAGES)) u_back (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (req_seen),
    .q     (ack_s)
  );

  assign edge_seen   = (ack_s == req_q);
  assign window_full = (cnt_q == WIN_MAX);
  assign trip        = det_en && !restart && !fail_clr && window_full;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (edge_seen) req_q <= ~req_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!det_en || restart || fail_clr || edge_seen) begin
      cnt_q <= '0;
    end else if (!window_full) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      fail_q <= trip | (fail_q & ~fail_clr);
      irq_q  <= trip & ~fail_q;
    end
  end

  assign fail     = fail_q;
  assign fail_irq = irq_q;

  // R4: the event lasts one reference cycle
  assert_irq_single_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_irq |=> !fail_irq);

  // R4: the event marks the rise of the flag
  assert_irq_on_rise_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_irq |-> (fail && !$past(fail)));

  // R5: the flag holds until cleared
  assert_sticky_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail && !fail_clr) |=> fail);

  // R6: no rise without the enable
  assert_rise_needs_en_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail) |-> $past(det_en));

  // R2: a rise only after a full window
  assert_rise_after_window_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail) |-> $past(window_full));

endmodule

// File: rtl/cfd_clksel.sv
module cfd_clksel
  import cfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       wdo_osc_en,
  input  logic       prim_fail,
  output logic [1:0] eff_sel,
  output logic       fallback,
  output logic       src_changed
);
  logic [1:0] src_q;
  logic [1:0] eff_q;
  logic       fb_q;
  logic       fb_ok;
  logic       fb_d;
  logic       live_q;

  assign src_changed = (src_sel != src_q);
  assign fb_ok       = wdo_osc_en && (src_sel != SRC_WDOSC);
  assign fb_d        = prim_fail && (fb_q || fb_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_INTOSC;
      eff_q  <= SRC_INTOSC;
      fb_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      src_q  <= src_sel;
      eff_q  <= fb_d ? SRC_WDOSC : src_sel;
      fb_q   <= fb_d;
      live_q <= 1'b1;
    end
  end

  assign eff_sel  = eff_q;
  assign fallback = fb_q;

  // R8: fallback exists only on a failure seen one edge earlier
  assert_fb_after_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |-> $past(prim_fail));

  // R9: entry requires an available, non-selected watchdog oscillator
  assert_fb_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback) |-> ($past(wdo_osc_en) && ($past(src_sel) != SRC_WDOSC)));

  // R10: outside fallback the select trails the request by one edge
  assert_sel_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !fallback) |-> (eff_sel == $past(src_sel)));

endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard
  import cfd_pkg::*;
#(
  parameter int unsigned WDO_HZ      = 10000,
  parameter int unsigned PRIM_MIN_HZ = 1000,
  parameter int unsigned SYS_MAX_HZ  = 20000000,
  parameter int unsigned WDO_MIN_HZ  = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       wdo_clk,
  input  logic       prim_clk,
  input  logic       rst_n,
  input  logic       prim_det_en,
  input  logic       prim_fail_clr,
  input  logic       wdo_osc_en,
  input  logic [1:0] src_sel,
  input  logic       wdo_det_en,
  input  logic       wdo_fail_clr,
  output logic       prim_fail,
  output logic       prim_fail_irq,
  output logic       wdo_fail,
  output logic       wdo_fail_irq,
  output logic [1:0] eff_sel,
  output logic       fallback,
  output logic       sys_clk
);
  localparam int unsigned PRIM_WIN = window_cycles(WDO_HZ, PRIM_MIN_HZ);
  localparam int unsigned WDO_WIN  = window_cycles(SYS_MAX_HZ, WDO_MIN_HZ);

  logic src_changed;

  // Primary clock measured against the watchdog oscillator.
  cfd_monitor #(.LIMIT(PRIM_WIN), .SYNC_STAGES(SYNC_STAGES)) u_prim_mon (
    .ref_clk  (wdo_clk),
    .meas_clk (prim_clk),
    .rst_n    (rst_n),
    .det_en   (prim_det_en),
    .restart  (src_changed),
    .fail_clr (prim_fail_clr),
    .fail     (prim_fail),
    .fail_irq (prim_fail_irq)
  );

  // Watchdog oscillator measured against the primary clock.
  cfd_monitor #(.LIMIT(WDO_WIN), .SYNC_STAGES(SYNC_STAGES)) u_wdo_mon (
    .ref_clk  (prim_clk),
    .meas_clk (wdo_clk),
    .rst_n    (rst_n),
    .det_en   (wdo_det_en),
    .restart  (1'b0),
    .fail_clr (wdo_fail_clr),
    .fail     (wdo_fail),
    .fail_irq (wdo_fail_irq)
  );

  cfd_clksel u_sel (
    .clk         (wdo_clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .wdo_osc_en  (wdo_osc_en),
    .prim_fail   (prim_fail),
    .eff_sel     (eff_sel),
    .fallback    (fallback),
    .src_changed (src_changed)
  );

  // Behavioural stand-in for a glitch-free clock switch.
  assign sys_clk = (eff_sel == SRC_WDOSC) ? wdo_clk : prim_clk;

endmodule

// File: tb/tb_clk_fail_guard.sv
module tb_clk_fail_guard;
  localparam int L  = 16000 / 1000;
  localparam int WL = 64000 / 1000;

  logic wdo_clk = 1'b0, prim_clk = 1'b0, rst_n = 1'b1;
  logic wdo_run = 1'b1, prim_run = 1'b1;
  logic prim_det_en = 1'b0, prim_fail_clr = 1'b0, wdo_osc_en = 1'b1;
  logic [1:0] src_sel = 2'b01;
  logic wdo_det_en = 1'b1, wdo_fail_clr = 1'b0;
  logic prim_fail, prim_fail_irq, wdo_fail, wdo_fail_irq, fallback, sys_clk;
  logic [1:0] eff_sel;

  int checks = 0, failures = 0, cyc = 0, wirq = 0;

  typedef struct {
    int         at;
    string      req;
    logic [4:0] val;  // {fail, irq, sel[1:0], fallback}
  } exp_t;
  exp_t sbq[$];

  clk_fail_guard #(.WDO_HZ(16000), .PRIM_MIN_HZ(1000), .SYS_MAX_HZ(64000),
                   .WDO_MIN_HZ(1000), .SYNC_STAGES(2)) dut (
    .wdo_clk(wdo_clk), .prim_clk(prim_clk), .rst_n(rst_n),
    .prim_det_en(prim_det_en), .prim_fail_clr(prim_fail_clr),
    .wdo_osc_en(wdo_osc_en), .src_sel(src_sel), .wdo_det_en(wdo_det_en),
    .wdo_fail_clr(wdo_fail_clr), .prim_fail(prim_fail),
    .prim_fail_irq(prim_fail_irq), .wdo_fail(wdo_fail),
    .wdo_fail_irq(wdo_fail_irq), .eff_sel(eff_sel), .fallback(fallback),
    .sys_clk(sys_clk));

  initial forever begin #4; if (wdo_run) wdo_clk = ~wdo_clk; end
  initial forever begin #2.5; if (prim_run) prim_clk = ~prim_clk; end

  always @(posedge wdo_clk) cyc <= cyc + 1;
  always @(negedge prim_clk) if (wdo_fail_irq) wirq <= wirq + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_at(input int at, input string req, input logic f,
                           input logic i, input logic [1:0] s, input logic fb);
    exp_t e;
    e.at = at; e.req = req; e.val = {f, i, s, fb};
    sbq.push_back(e);
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge wdo_clk);
  endtask

  task automatic ptick(input int k);
    repeat (k) @(negedge prim_clk);
  endtask

  task automatic clr_prim();
    prim_fail_clr = 1'b1;
    tick(1);
    prim_fail_clr = 1'b0;
  endtask

  // Scoreboard monitor: pops expectations as their cycle arrives.
  initial forever begin
    @(posedge wdo_clk);
    #2;
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      if (e.at < cyc) chk(e.req, "missed sample slot", 32'(cyc), 32'(e.at));
      else chk(e.req, $sformatf("{fail,irq,sel,fb} @%0d", cyc),
               32'({prim_fail, prim_fail_irq, eff_sel, fallback}), 32'(e.val));
    end
  end

  initial begin
    #(64'd200000 * 8);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    #1 rst_n = 1'b0;
    tick(4);
    expect_at(cyc + 1, "R1", 0, 0, 2'b00, 0);
    tick(1);
    chk("R1", "wdo_fail in reset", 32'(wdo_fail), 0);
    rst_n = 1'b1;
    expect_at(cyc + 1, "R10", 0, 0, 2'b01, 0);
    tick(2);

    // R3: running primary never flags
    prim_det_en = 1'b1;
    n = cyc;
    expect_at(n + L + 5, "R3", 0, 0, 2'b01, 0);
    expect_at(n + 3 * L, "R3", 0, 0, 2'b01, 0);
    tick(3 * L + 1);

    // R6: stopped primary with detection off stays quiet
    prim_det_en = 1'b0;
    prim_run = 1'b0;
    n = cyc;
    expect_at(n + 3 * L, "R6", 0, 0, 2'b01, 0);
    tick(3 * L + 1);

    // R2, R4, R8: exact trip edge and fallback
    prim_det_en = 1'b1;
    n = cyc;
    expect_at(n + L, "R2", 0, 0, 2'b01, 0);
    expect_at(n + L + 1, "R2", 1, 1, 2'b01, 0);
    expect_at(n + L + 2, "R4", 1, 0, 2'b11, 1);
    expect_at(n + L + 8, "R8", 1, 0, 2'b11, 1);
    tick(L + 8);
    @(posedge wdo_clk); #1;
    chk("R12", "sys_clk high on watchdog", 32'(sys_clk), 1);
    @(negedge wdo_clk); #1;
    chk("R12", "sys_clk low on watchdog", 32'(sys_clk), 0);
    tick(1);

    // R5: sticky, then clear; R8 exit
    prim_run = 1'b1;
    tick(10);
    expect_at(cyc + 1, "R5", 1, 0, 2'b11, 1);
    tick(1);
    prim_fail_clr = 1'b1;
    n = cyc;
    expect_at(n + 1, "R5", 0, 0, 2'b11, 1);
    expect_at(n + 2, "R8", 0, 0, 2'b01, 0);
    expect_at(n + 3 * L, "R5", 0, 0, 2'b01, 0);
    tick(1);
    prim_fail_clr = 1'b0;
    tick(3 * L);

    // R7: select change restarts the window
    prim_det_en = 1'b0;
    prim_run = 1'b0;
    tick(8);
    prim_det_en = 1'b1;
    n = cyc;
    tick(L - 4);
    src_sel = 2'b10;
    expect_at(n + L - 3, "R10", 0, 0, 2'b10, 0);
    expect_at(n + L + 1, "R7", 0, 0, 2'b10, 0);
    expect_at(n + 2 * L - 3, "R7", 0, 0, 2'b10, 0);
    expect_at(n + 2 * L - 2, "R7", 1, 1, 2'b10, 0);
    expect_at(n + 2 * L - 1, "R8", 1, 0, 2'b11, 1);
    tick(L + 4);
    prim_run = 1'b1;
    tick(8);
    clr_prim();
    expect_at(cyc + 1, "R8", 0, 0, 2'b10, 0);
    tick(2);

    // R9: watchdog already selected
    prim_det_en = 1'b0;
    src_sel = 2'b11;
    prim_run = 1'b0;
    tick(8);
    prim_det_en = 1'b1;
    n = cyc;
    expect_at(n + L + 1, "R9", 1, 1, 2'b11, 0);
    expect_at(n + L + 4, "R9", 1, 0, 2'b11, 0);
    tick(L + 5);
    prim_run = 1'b1;
    tick(8);
    clr_prim();
    tick(2);

    // R9: watchdog oscillator not available
    prim_det_en = 1'b0;
    src_sel = 2'b01;
    wdo_osc_en = 1'b0;
    prim_run = 1'b0;
    tick(8);
    prim_det_en = 1'b1;
    n = cyc;
    expect_at(n + L + 1, "R9", 1, 1, 2'b01, 0);
    expect_at(n + L + 4, "R9", 1, 0, 2'b01, 0);
    tick(L + 5);
    #1 chk("R12", "sys_clk tracks primary", 32'(sys_clk), 32'(prim_clk));
    prim_run = 1'b1;
    tick(8);
    #1 chk("R12", "sys_clk tracks running primary", 32'(sys_clk), 32'(prim_clk));
    clr_prim();
    wdo_osc_en = 1'b1;
    expect_at(cyc + 2, "R5", 0, 0, 2'b01, 0);
    tick(4);
    chk("R10", "scoreboard drained", 32'(sbq.size()), 0);

    // R11: watchdog oscillator monitor in the primary domain
    ptick(200);
    chk("R11", "wdo_fail while running", 32'(wdo_fail), 0);
    chk("R11", "no watchdog events while running", 32'(wirq), 0);
    @(negedge wdo_clk);
    wdo_run = 1'b0;
    ptick(WL - 16);
    chk("R11", "wdo_fail before window", 32'(wdo_fail), 0);
    ptick(32);
    chk("R11", "wdo_fail after window", 32'(wdo_fail), 1);
    chk("R11", "one watchdog event", 32'(wirq), 1);
    wdo_fail_clr = 1'b1;
    ptick(1);
    chk("R11", "wdo_fail cleared", 32'(wdo_fail), 0);
    wdo_fail_clr = 1'b0;
    ptick(WL + 16);
    chk("R11", "wdo_fail re-trips", 32'(wdo_fail), 1);
    chk("R11", "second watchdog event", 32'(wirq), 2);
    wdo_det_en = 1'b0;
    wdo_fail_clr = 1'b1;
    ptick(1);
    wdo_fail_clr = 1'b0;
    ptick(3 * WL);
    chk("R11", "wdo_fail with detection off", 32'(wdo_fail), 0);
    chk("R11", "no event with detection off", 32'(wirq), 2);
    wdo_run = 1'b1;
    ptick(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule